// File: doc/BRIEF.md
# Random Number Source Seed-Error Recovery Sequencer

This block is a bus master that sits in front of a hardware entropy source's register block and turns it into a stream of 32-bit random words on a valid/ready interface. After reset it programs the source's control register. In the variant with a conditional reset, that includes a clock-divider exponent worked out at elaboration from the input clock rate. It then polls the status register and hands each fresh data word downstream.

Seed faults are repaired without software help. The variant with a conditional reset pulses that reset when the fault is still current, or only acknowledges the fault when the source has already recovered by itself. The variant without it acknowledges the fault, reads and throws away a fixed number of words to clean the pipeline, then checks that the fault has not come back. A data word of zero counts as a late seed fault. Each output word gets a small budget of repair attempts. A failed repair, or one fault too many, halts the block with a fatal flag. A poll that waits too long halts it with a timeout flag. A slow-clock indication raises a one-cycle warning, and operation continues.

Top module: `rng_seed_seq`

## Requirements
- R1: With the conditional-reset variant, start-up makes two control writes at offset 0x0: first the divider exponent in bits 20:16, the clock-error-detect bit 5 and the conditional-reset bit 30; then the same value with bit 30 cleared and the enable bit 2 set. The exponent is the smallest shift that brings the input clock rate to at most 48 MHz (2 for 100 MHz). Bit 5 is written 1 only when clock-error detection is not requested.
- R2: Without the conditional reset, start-up makes a single control write of the enable bit 2 plus bit 5 (1 when detection is not requested), with no divider field. The ceiling in that variant is 3 MHz.
- R3: Data words read from offset 0x8 appear on `word_data` in read order. `word_valid` holds, with the data stable, until `word_ready` is high. A delivered word is never zero. Reset clears `word_valid`, `bus_req` and all flags.
- R4: When a status read at offset 0x4 shows the clock-error bit 5, `slow_clk_warn` pulses for one cycle, status is written with 0, and the word is still delivered.
- R5: With the conditional-reset variant, a seed fault whose current-state bit 2 is set causes a control write with bit 30 high and then low. The block then waits for bit 30 to read clear, checks that the seed bit 6 is clear, waits for bit 2 to clear, and resumes.
- R6: With the conditional-reset variant, a seed fault with only bit 6 set causes no reset pulse. Status is written with its last read value minus bit 6, and operation resumes.
- R7: Without the conditional reset, a seed fault leads to a status write with bit 6 cleared, then 12 discarded data reads, then a status check. The next word delivered is the 13th data word read.
- R8: A data word read as zero is discarded and handled as a seed fault.
- R9: Up to 3 repairs are allowed per output word. The 4th seed fault before a word is delivered sets `seed_fatal`. The budget restarts after each delivered word.
- R10: If the post-repair status check still shows bit 6, `seed_fatal` is set and the block halts with no further words.
- R11: A data-ready poll that gets no answer within TMO_POLL cycles (recovery waits use TMO_RECOV) sets `poll_timeout` and halts the block.
- R12: A bus request keeps `bus_req`, `bus_we`, `bus_addr` and `bus_wdata` stable until `bus_ack`, and only one request is outstanding at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_req | output | 1 | Register access request |
| bus_we | output | 1 | Access is a write |
| bus_addr | output | 32 | Register byte address |
| bus_wdata | output | 32 | Write data |
| bus_ack | input | 1 | Access complete, read data valid |
| bus_rdata | input | 32 | Read data |
| word_valid | output | 1 | Random word available |
| word_data | output | 32 | Random word |
| word_ready | input | 1 | Consumer accepts the word |
| slow_clk_warn | output | 1 | One-cycle slow-clock warning |
| seed_fatal | output | 1 | Unrecoverable seed fault, sticky |
| poll_timeout | output | 1 | Wait timed out, sticky |

## Verification
The bench puts a register model behind each variant and injects faults at chosen status reads. A repair path that skips the reset pulse, or flushes the wrong number of words, would deliver the wrong word from the scripted sequence. Runs of three and four zero words probe the budget edge. An off-by-one budget, or one that is not reloaded after delivery, would either report a fatal fault too early or hide the failure. A status bit 6 that stays set must end in a halt. A design that forgot the post-repair check would keep producing words. A stalled ready bit must end in the timeout flag and not in a hang. The start-up control words are compared bit by bit, so a divider or inverted-detection error would show.

// File: rtl/rng_seq_pkg.sv
package rng_seq_pkg;
  localparam int unsigned DATA_W = 32;

  // register offsets
  localparam logic [31:0] OFS_CTRL = 32'h0;
  localparam logic [31:0] OFS_STAT = 32'h4;
  localparam logic [31:0] OFS_DATA = 32'h8;

  // control bits
  localparam int CTRL_EN_BIT   = 2;
  localparam int CTRL_CED_BIT  = 5;
  localparam int CTRL_DIV_LSB  = 16;
  localparam int CTRL_CRST_BIT = 30;

  // status bits
  localparam int ST_RDY_BIT = 0;
  localparam int ST_SEC_BIT = 2;
  localparam int ST_CEI_BIT = 5;
  localparam int ST_SEI_BIT = 6;

  typedef enum logic [4:0] {
    S_CFG_A, S_CFG_B, S_CFG_WAITCR, S_CLR_SR, S_POLL, S_CLR_CE,
    S_RD_DATA, S_OUT, S_REC_SR, S_REC_SET, S_REC_REL, S_REC_WAITCR,
    S_REC_CLRSEI, S_FLUSH, S_REC_CHK, S_REC_WAITSECS, S_FATAL, S_TMO
  } seq_state_e;

  // smallest shift that brings clk_hz down to max_hz or below
  function automatic int unsigned div_exp(longint unsigned clk_hz,
                                          longint unsigned max_hz);
    int unsigned e = 0;
    for (int i = 0; i < 32; i++)
      if ((clk_hz >> e) > max_hz) e++;
    return e;
  endfunction
endpackage

// File: rtl/rng_wait_timer.sv
module rng_wait_timer #(
  parameter int unsigned LIMIT = 10000
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic expired
);
  localparam int W = $clog2(LIMIT + 1);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || !run)
      cnt_q <= '0;
    else if (cnt_q != W'(LIMIT))
      cnt_q <= cnt_q + 1'b1;
  end

  assign expired = run && (cnt_q == W'(LIMIT));
endmodule

// File: rtl/rng_retry_budget.sv
module rng_retry_budget #(
  parameter int unsigned MAX_TRIES = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic bump,
  output logic spent
);
  localparam int W = $clog2(MAX_TRIES + 1);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || clr)
      cnt_q <= '0;
    else if (bump)
      cnt_q <= cnt_q + 1'b1;
  end

  assign spent = (cnt_q == W'(MAX_TRIES));

  // R9: the sequencer never starts a repair once the budget is used up
  p_no_bump_when_spent_r9: assert property (@(posedge clk) disable iff (rst)
    bump |-> !spent);
endmodule

// File: rtl/rng_seed_seq.sv
module rng_seed_seq
  import rng_seq_pkg::*;
#(
  parameter bit              COND_RESET  = 1'b1,
  parameter longint unsigned CLK_HZ      = 100_000_000,
  parameter bit              CED_ON      = 1'b1,
  parameter int unsigned     TMO_POLL    = 10000,
  parameter int unsigned     TMO_RECOV   = 100000,
  parameter int unsigned     RETRIES     = 3,
  parameter int unsigned     FLUSH_WORDS = 12,
  parameter logic [31:0]     BASE_ADDR   = 32'h0
) (
  input  logic        clk,
  input  logic        rst,
  output logic        bus_req,
  output logic        bus_we,
  output logic [31:0] bus_addr,
  output logic [31:0] bus_wdata,
  input  logic        bus_ack,
  input  logic [31:0] bus_rdata,
  output logic        word_valid,
  output logic [31:0] word_data,
  input  logic        word_ready,
  output logic        slow_clk_warn,
  output logic        seed_fatal,
  output logic        poll_timeout
);
  localparam longint unsigned MAX_HZ = COND_RESET ? 64'd48_000_000 : 64'd3_000_000;
  localparam int unsigned DIV_EXP = div_exp(CLK_HZ, MAX_HZ);
  localparam logic [31:0] DIV_FIELD = COND_RESET ? (32'(DIV_EXP) << CTRL_DIV_LSB) : 32'h0;
  localparam logic [31:0] CED_FIELD = CED_ON ? 32'h0 : (32'h1 << CTRL_CED_BIT);
  localparam logic [31:0] CRST_MASK = 32'h1 << CTRL_CRST_BIT;
  localparam logic [31:0] CFG_RUN   = DIV_FIELD | CED_FIELD | (32'h1 << CTRL_EN_BIT);
  localparam logic [31:0] CFG_HOLD  = DIV_FIELD | CED_FIELD | CRST_MASK;
  localparam int FLW = $clog2(FLUSH_WORDS + 1);

  seq_state_e state_q;
  logic [31:0] sr_q, data_q, addr_q, wdata_q;
  logic [FLW-1:0] flush_q;
  logic req_q, we_q, boot_q, valid_q, warn_q, fatal_q, tmo_q;

  // access wanted by the current state
  logic acc_bus, acc_we;
  logic [31:0] acc_ofs, acc_wd;
  always_comb begin
    acc_bus = 1'b1; acc_we = 1'b0; acc_ofs = OFS_STAT; acc_wd = '0;
    case (state_q)
      S_CFG_A:      begin acc_we = 1'b1; acc_ofs = OFS_CTRL; acc_wd = CFG_HOLD; end
      S_CFG_B:      begin acc_we = 1'b1; acc_ofs = OFS_CTRL; acc_wd = CFG_RUN; end
      S_REC_SET:    begin acc_we = 1'b1; acc_ofs = OFS_CTRL; acc_wd = CFG_RUN | CRST_MASK; end
      S_REC_REL:    begin acc_we = 1'b1; acc_ofs = OFS_CTRL; acc_wd = CFG_RUN; end
      S_CFG_WAITCR, S_REC_WAITCR: acc_ofs = OFS_CTRL;
      S_CLR_SR, S_CLR_CE: acc_we = 1'b1;
      S_REC_CLRSEI: begin acc_we = 1'b1; acc_wd = sr_q & ~(32'h1 << ST_SEI_BIT); end
      S_POLL, S_REC_SR, S_REC_CHK, S_REC_WAITSECS: acc_ofs = OFS_STAT;
      S_RD_DATA, S_FLUSH: acc_ofs = OFS_DATA;
      default: acc_bus = 1'b0;
    endcase
  end

  // single-outstanding bus port
  always_ff @(posedge clk) begin
    if (rst) begin
      req_q <= 1'b0; we_q <= 1'b0; addr_q <= '0; wdata_q <= '0;
    end else if (req_q) begin
      if (bus_ack) req_q <= 1'b0;
    end else if (acc_bus) begin
      req_q   <= 1'b1;
      we_q    <= acc_we;
      addr_q  <= BASE_ADDR + acc_ofs;
      wdata_q <= acc_wd;
    end
  end

  wire done    = req_q && bus_ack;
  wire poll_ok = boot_q ? bus_rdata[ST_RDY_BIT] : (bus_rdata != '0);
  wire seed_hit = done && (((state_q == S_POLL) && poll_ok && bus_rdata[ST_SEI_BIT]) ||
                           ((state_q == S_RD_DATA) && (bus_rdata == '0)));

  logic spent, tmo_poll, tmo_rec;
  logic bump, clr_budget;
  assign bump       = seed_hit && !spent;
  assign clr_budget = valid_q && word_ready;

  rng_retry_budget #(.MAX_TRIES(RETRIES)) u_budget (
    .clk(clk), .rst(rst), .clr(clr_budget), .bump(bump), .spent(spent));

  rng_wait_timer #(.LIMIT(TMO_POLL)) u_tmo_poll (
    .clk(clk), .rst(rst),
    .run((state_q == S_CFG_WAITCR) || (state_q == S_POLL)), .expired(tmo_poll));

  rng_wait_timer #(.LIMIT(TMO_RECOV)) u_tmo_rec (
    .clk(clk), .rst(rst),
    .run((state_q == S_REC_WAITCR) || (state_q == S_REC_WAITSECS)), .expired(tmo_rec));

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= COND_RESET ? S_CFG_A : S_CFG_B;
      sr_q <= '0; data_q <= '0; flush_q <= '0;
      boot_q <= 1'b1; valid_q <= 1'b0; warn_q <= 1'b0;
      fatal_q <= 1'b0; tmo_q <= 1'b0;
    end else begin
      warn_q <= 1'b0;
      case (state_q)
        S_CFG_A: if (done) state_q <= S_CFG_B;
        S_CFG_B: if (done) state_q <= COND_RESET ? S_CFG_WAITCR : S_CLR_SR;
        S_CFG_WAITCR:
          if (done && !bus_rdata[CTRL_CRST_BIT]) state_q <= S_CLR_SR;
          else if (tmo_poll) state_q <= S_TMO;
        S_CLR_SR: if (done) state_q <= S_POLL;
        S_POLL:
          if (done && poll_ok) begin
            boot_q <= 1'b0;
            if (bus_rdata[ST_SEI_BIT]) state_q <= spent ? S_FATAL : S_REC_SR;
            else if (bus_rdata[ST_CEI_BIT]) begin
              warn_q  <= 1'b1;
              state_q <= S_CLR_CE;
            end else state_q <= S_RD_DATA;
          end else if (tmo_poll) state_q <= S_TMO;
        S_CLR_CE: if (done) state_q <= S_RD_DATA;
        S_RD_DATA:
          if (done) begin
            if (bus_rdata == '0) state_q <= spent ? S_FATAL : S_REC_SR;
            else begin
              data_q  <= bus_rdata;
              valid_q <= 1'b1;
              state_q <= S_OUT;
            end
          end
        S_OUT:
          if (word_ready) begin
            valid_q <= 1'b0;
            state_q <= S_POLL;
          end
        S_REC_SR:
          if (done) begin
            sr_q    <= bus_rdata;
            state_q <= (COND_RESET && bus_rdata[ST_SEC_BIT]) ? S_REC_SET : S_REC_CLRSEI;
          end
        S_REC_SET: if (done) state_q <= S_REC_REL;
        S_REC_REL: if (done) state_q <= S_REC_WAITCR;
        S_REC_WAITCR:
          if (done && !bus_rdata[CTRL_CRST_BIT]) state_q <= S_REC_CHK;
          else if (tmo_rec) state_q <= S_TMO;
        S_REC_CLRSEI:
          if (done) begin
            flush_q <= '0;
            state_q <= COND_RESET ? S_POLL : S_FLUSH;
          end
        S_FLUSH:
          if (done) begin
            if (flush_q == FLW'(FLUSH_WORDS - 1)) state_q <= S_REC_CHK;
            else flush_q <= flush_q + 1'b1;
          end
        S_REC_CHK:
          if (done) begin
            if (bus_rdata[ST_SEI_BIT]) state_q <= S_FATAL;
            else state_q <= COND_RESET ? S_REC_WAITSECS : S_POLL;
          end
        S_REC_WAITSECS:
          if (done && !bus_rdata[ST_SEC_BIT]) state_q <= S_POLL;
          else if (tmo_rec) state_q <= S_TMO;
        S_FATAL: fatal_q <= 1'b1;
        S_TMO:   tmo_q   <= 1'b1;
        default: state_q <= S_FATAL;
      endcase
    end
  end

  assign bus_req       = req_q;
  assign bus_we        = we_q;
  assign bus_addr      = addr_q;
  assign bus_wdata     = wdata_q;
  assign word_valid    = valid_q;
  assign word_data     = data_q;
  assign slow_clk_warn = warn_q;
  assign seed_fatal    = fatal_q;
  assign poll_timeout  = tmo_q;

  // R12: request fields hold until acknowledged
  p_req_stable_r12: assert property (@(posedge clk) disable iff (rst)
    (bus_req && !bus_ack) |=> (bus_req && $stable(bus_addr) && $stable(bus_we) && $stable(bus_wdata)));
  // R3: an offered word waits unchanged for the consumer
  p_word_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (word_valid && !word_ready) |=> (word_valid && $stable(word_data)));
  // R3, R8: zero never reaches the output
  p_word_nonzero_r8: assert property (@(posedge clk) disable iff (rst)
    word_valid |-> (word_data != '0));
  // R4: warning lasts a single cycle
  p_warn_pulse_r4: assert property (@(posedge clk) disable iff (rst)
    slow_clk_warn |=> !slow_clk_warn);
  // R10: fatal state is final and silent
  p_fatal_hold_r10: assert property (@(posedge clk) disable iff (rst)
    seed_fatal |=> (seed_fatal && !word_valid));
  // R11: timeout state is final and silent
  p_tmo_hold_r11: assert property (@(posedge clk) disable iff (rst)
    poll_timeout |=> (poll_timeout && !word_valid && !seed_fatal));
endmodule

// File: tb/rng_seed_seq_tb.sv
module rng_reg_model (
  input  logic        clk,
  input  logic        rst,
  input  logic        req,
  input  logic        we,
  input  logic [31:0] addr,
  input  logic [31:0] wdata,
  output logic        ack,
  output logic [31:0] rdata,
  input  int          inj_at,
  input  logic [31:0] inj_bits,
  input  logic        crst_fixes,
  input  logic        sticky,
  input  logic        stall,
  input  logic [15:0] zero_mask,
  output int          cr_wr_cnt,
  output logic [31:0] cr_wr0,
  output logic [31:0] cr_wr1,
  output int          crst_cnt,
  output logic [31:0] sr_wr_last
);
  logic [31:0] err_q, cr_q, sr_view;
  int sr_rd, dr_rd;

  function automatic logic [31:0] word_at(int i);
    return 32'h5A00_0100 + 32'(i) * 32'h0001_0011;
  endfunction

  assign sr_view = err_q | ((sr_rd + 1 == inj_at) ? inj_bits : 32'h0);

  always_ff @(posedge clk) begin
    if (rst) begin
      ack <= 0; rdata <= 0; err_q <= 0; cr_q <= 0; sr_rd <= 0; dr_rd <= 0;
      cr_wr_cnt <= 0; cr_wr0 <= 0; cr_wr1 <= 0; crst_cnt <= 0; sr_wr_last <= 32'hFFFF_FFFF;
    end else begin
      ack <= 1'b0;
      if (req && !ack) begin
        ack   <= 1'b1;
        rdata <= 32'h0;
        if (addr[3:0] == 4'h0) begin
          if (we) begin
            cr_q <= wdata;
            if (cr_wr_cnt == 0) cr_wr0 <= wdata;
            if (cr_wr_cnt == 1) cr_wr1 <= wdata;
            cr_wr_cnt <= cr_wr_cnt + 1;
            if (wdata[30]) begin
              crst_cnt <= crst_cnt + 1;
              if (crst_fixes && !sticky) err_q <= err_q & ~32'h44;
            end
          end else rdata <= cr_q & ~(32'h1 << 30);
        end else if (addr[3:0] == 4'h4) begin
          if (we) begin
            sr_wr_last <= wdata;
            if (!sticky) err_q <= wdata & 32'h64;
          end else begin
            sr_rd <= sr_rd + 1;
            err_q <= sr_view;
            rdata <= sr_view | (stall ? 32'h0 : 32'h1);
          end
        end else if (!we) begin
          rdata <= (dr_rd < 16 && zero_mask[dr_rd[3:0]]) ? 32'h0 : word_at(dr_rd);
          dr_rd <= dr_rd + 1;
        end
      end
    end
  end
endmodule

module rng_seed_seq_tb;
  logic clk = 0;
  logic rst = 1;
  always #5 clk = ~clk;

  int checks = 0;
  int errors = 0;

  int          inj_at = 0;
  logic [31:0] inj_bits = 0;
  logic        crst_fixes = 1, sticky = 0, stall = 0;
  logic [15:0] zero_mask = 0;
  logic        rdy = 0;

  // conditional-reset instance
  logic        req_a, we_a, ack_a, valid_a, warn_a, fatal_a, tmo_a;
  logic [31:0] addr_a, wd_a, rd_a, data_a, crw0_a, crw1_a, srl_a;
  int          crcnt_a, crst_a;
  // plain instance
  logic        req_b, we_b, ack_b, valid_b, warn_b, fatal_b, tmo_b;
  logic [31:0] addr_b, wd_b, rd_b, data_b, crw0_b, crw1_b, srl_b;
  int          crcnt_b, crst_b;

  rng_seed_seq #(.COND_RESET(1'b1), .CLK_HZ(100_000_000), .CED_ON(1'b1),
                 .TMO_POLL(40), .TMO_RECOV(400)) u_dut (
    .clk(clk), .rst(rst), .bus_req(req_a), .bus_we(we_a), .bus_addr(addr_a),
    .bus_wdata(wd_a), .bus_ack(ack_a), .bus_rdata(rd_a), .word_valid(valid_a),
    .word_data(data_a), .word_ready(rdy), .slow_clk_warn(warn_a),
    .seed_fatal(fatal_a), .poll_timeout(tmo_a));

  rng_reg_model u_mdl_a (
    .clk(clk), .rst(rst), .req(req_a), .we(we_a), .addr(addr_a), .wdata(wd_a),
    .ack(ack_a), .rdata(rd_a), .inj_at(inj_at), .inj_bits(inj_bits),
    .crst_fixes(crst_fixes), .sticky(sticky), .stall(stall), .zero_mask(zero_mask),
    .cr_wr_cnt(crcnt_a), .cr_wr0(crw0_a), .cr_wr1(crw1_a), .crst_cnt(crst_a),
    .sr_wr_last(srl_a));

  rng_seed_seq #(.COND_RESET(1'b0), .CLK_HZ(100_000_000), .CED_ON(1'b0),
                 .TMO_POLL(40), .TMO_RECOV(400)) u_dut_nc (
    .clk(clk), .rst(rst), .bus_req(req_b), .bus_we(we_b), .bus_addr(addr_b),
    .bus_wdata(wd_b), .bus_ack(ack_b), .bus_rdata(rd_b), .word_valid(valid_b),
    .word_data(data_b), .word_ready(1'b1), .slow_clk_warn(warn_b),
    .seed_fatal(fatal_b), .poll_timeout(tmo_b));

  rng_reg_model u_mdl_b (
    .clk(clk), .rst(rst), .req(req_b), .we(we_b), .addr(addr_b), .wdata(wd_b),
    .ack(ack_b), .rdata(rd_b), .inj_at(inj_at), .inj_bits(inj_bits),
    .crst_fixes(crst_fixes), .sticky(sticky), .stall(stall), .zero_mask(zero_mask),
    .cr_wr_cnt(crcnt_b), .cr_wr0(crw0_b), .cr_wr1(crw1_b), .crst_cnt(crst_b),
    .sr_wr_last(srl_b));

  // monitors
  int warn_cnt, nc_cnt, bus_viol;
  logic [31:0] nc_first, addr_p;
  logic req_p, ack_p;
  always @(posedge clk) begin
    if (rst) begin
      warn_cnt <= 0; nc_cnt <= 0; nc_first <= 0; bus_viol <= 0;
      req_p <= 0; ack_p <= 0; addr_p <= 0;
    end else begin
      if (warn_a) warn_cnt <= warn_cnt + 1;
      if (valid_b) begin
        if (nc_cnt == 0) nc_first <= data_b;
        nc_cnt <= nc_cnt + 1;
      end
      if (req_p && !ack_p && (!req_a || addr_a != addr_p)) bus_viol <= bus_viol + 1;
      req_p <= req_a; ack_p <= ack_a; addr_p <= addr_a;
    end
  end

  function automatic logic [31:0] exp_word(int i);
    return 32'h5A00_0100 + 32'(i) * 32'h0001_0011;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic start(input int ia, input logic [31:0] ib, input logic fix,
                       input logic stk, input logic stl, input logic [15:0] zm);
    @(negedge clk);
    rst = 1; rdy = 0;
    inj_at = ia; inj_bits = ib; crst_fixes = fix; sticky = stk; stall = stl; zero_mask = zm;
    repeat (3) @(negedge clk);
    rst = 0;
  endtask

  task automatic wait_valid(input string tag);
    for (int n = 0; n < 600 && !valid_a; n++) @(negedge clk);
    chk({tag, " word_valid seen"}, {31'h0, valid_a}, 32'h1);
  endtask

  task automatic accept();
    rdy = 1; @(negedge clk); rdy = 0;
  endtask

  // consumer hold cycles per vector; expected word index is the loop index
  localparam int HOLD_TAB [6] = '{0, 3, 1, 0, 5, 2};

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    // reset state (R3, R12)
    repeat (2) @(negedge clk);
    chk("R3 reset word_valid", {31'h0, valid_a}, 32'h0);
    chk("R12 reset bus_req", {31'h0, req_a}, 32'h0);
    chk("R3 reset flags", {29'h0, warn_a, fatal_a, tmo_a}, 32'h0);

    // normal stream, vector table (R3)
    start(0, 0, 1, 0, 0, 16'h0);
    for (int k = 0; k < 6; k++) begin
      wait_valid("R3");
      chk("R3 word order", data_a, exp_word(k));
      for (int h = 0; h < HOLD_TAB[k]; h++) begin
        @(negedge clk);
        chk("R3 hold", {valid_a, data_a[30:0]}, {1'b1, exp_word(k)[30:0]});
      end
      accept();
    end
    chk("R1 first control write", crw0_a, 32'h4002_0000);
    chk("R1 second control write", crw1_a, 32'h0002_0004);
    chk("R2 control write value", crw0_b, 32'h0000_0024);
    chk("R2 single control write", 32'(crcnt_b), 32'd1);
    chk("R12 request stability", 32'(bus_viol), 32'd0);

    // seed fault with current-state bit (R5)
    start(1, 32'h44, 1, 0, 0, 16'h0);
    wait_valid("R5");
    chk("R5 word after reset pulse", data_a, exp_word(0));
    chk("R5 reset pulses", 32'(crst_a), 32'd2);
    chk("R5 no fatal", {31'h0, fatal_a}, 32'h0);

    // interrupt-only fault (R6), plain variant flush (R7)
    start(1, 32'h40, 1, 0, 0, 16'h0);
    wait_valid("R6");
    chk("R6 word", data_a, exp_word(0));
    chk("R6 no reset pulse", 32'(crst_a), 32'd1);
    chk("R6 status write", srl_a, 32'h1);
    for (int n = 0; n < 600 && nc_cnt == 0; n++) @(negedge clk);
    chk("R7 word after flush", nc_first, exp_word(12));

    // zero word (R8)
    start(0, 0, 1, 0, 0, 16'h0001);
    wait_valid("R8");
    chk("R8 zero skipped", data_a, exp_word(1));

    // budget exhausted (R9)
    start(0, 0, 1, 0, 0, 16'h000F);
    repeat (400) @(negedge clk);
    chk("R9 fourth fault fatal", {31'h0, fatal_a}, 32'h1);
    chk("R9 no word", {31'h0, valid_a}, 32'h0);

    // budget edge and reload (R9)
    start(0, 0, 1, 0, 0, 16'h0077);
    wait_valid("R9");
    chk("R9 three repairs ok", data_a, exp_word(3));
    accept();
    wait_valid("R9");
    chk("R9 budget reloaded", data_a, exp_word(7));
    chk("R9 no fatal", {31'h0, fatal_a}, 32'h0);

    // clock error (R4)
    start(1, 32'h20, 1, 0, 0, 16'h0);
    wait_valid("R4");
    chk("R4 word still delivered", data_a, exp_word(0));
    chk("R4 warn pulses", 32'(warn_cnt), 32'd1);
    chk("R4 status cleared", srl_a, 32'h0);

    // fault that persists (R10)
    start(1, 32'h44, 0, 1, 0, 16'h0);
    repeat (400) @(negedge clk);
    chk("R10 fatal cond variant", {31'h0, fatal_a}, 32'h1);
    chk("R10 fatal plain variant", {31'h0, fatal_b}, 32'h1);
    chk("R10 no timeout", {31'h0, tmo_a}, 32'h0);

    // stalled ready (R11)
    start(0, 0, 1, 0, 1, 16'h0);
    repeat (20) @(negedge clk);
    chk("R11 not yet expired", {31'h0, tmo_a}, 32'h0);
    repeat (130) @(negedge clk);
    chk("R11 timeout cond variant", {31'h0, tmo_a}, 32'h1);
    chk("R11 timeout plain variant", {31'h0, tmo_b}, 32'h1);
    chk("R11 no word", {31'h0, valid_a}, 32'h0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule